// File: doc/BRIEF.md
# Receive Frame Admission Filter

This block sits at the front of an Ethernet receive path. It decides, one frame at a time, whether an arriving frame is kept. It looks at the frame's destination address and at its length with the trailing check sequence removed. For every frame it reports a decision with a reason code and a set of single-cycle event pulses. For frames it keeps, it also reports a long-frame tag and the byte count that the downstream writer will store. Computing the check sequence and moving the data into memory belong to other blocks.

The filter holds a small set of configuration registers, written and read through a simple select/data port. These are the address-compare control, a single station-address entry with its enable bit, the maximum receive size and a mode register with accept-long and strip-check-sequence bits. A frame is presented for one cycle with `frm_valid`. The decision appears on the registered outputs on the next cycle. The address arrives as 48 bits, with byte 0 (the first byte on the wire) in bits [47:40].

Top module: `rx_admit_filter`

## Requirements
- R1: A frame whose length is below 14 or above 65531 is dropped with reason code 1 (SIZE), and no event pulse is raised for it.
- R2: Every frame that passes the R1 size check raises `ev_lentype` for one cycle, whatever the filter and length checks decide afterwards.
- R3: A destination of all ones is accepted when complement mode (control bit 3) is set, and otherwise only when accept-broadcast (control bit 2) is set. A rejected frame is dropped with reason 2 (FILTER).
- R4: A destination with bit 40 set that is not all ones is accepted when complement mode is set, and otherwise only when accept-multicast (control bit 1) is set. A rejected frame gets reason 2.
- R5: Any other destination is accepted when accept-all-unicast (control bit 0) is set. Otherwise it matches only when compare-enable (control bit 4) is set, the entry enable bit is set and all 48 bits equal the station address. Complement mode inverts that match. A rejected frame gets reason 2.
- R6: Register select 2 holds address bytes 0..3 with byte 0 in bits [31:24]. Register select 3 holds bytes 4 and 5 in bits [31:24] and [23:16], and its bits [15:0] read as zero.
- R7: In the entry-enable register (select 1), only bit 0 can be written. Bits [31:1] always read as zero.
- R8: A frame that passes the filter and whose length plus 4 exceeds the maximum receive size (select 4) is dropped with reason 3 (OVERFLOW) and pulses `ev_overflow`. The maximum size resets to 0x800.
- R9: A frame that passes R8 and whose length plus 4 exceeds 1518 is handled by the accept-long bit (mode bit 0, select 5). With that bit clear, the frame is dropped with reason 4 (TOOLONG) and pulses `ev_toolong`. With it set, the frame is accepted with `dec_long` high.
- R10: For an accepted frame, `dec_len` is the length plus 4, or the length alone when strip mode (mode bit 1) is set. It reads zero for a dropped frame.
- R11: Each decision appears exactly one cycle after `frm_valid`. A configuration write made in the same cycle as a frame takes effect only for later frames.
- R12: After reset, the outputs are low and the registers read zero, except the maximum size. An accepted frame has reason code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 control, 1 enable, 2 address high, 3 address low, 4 max size, 5 mode) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register |
| frm_valid | input | 1 | Frame presented this cycle |
| frm_dst | input | 48 | Destination address, byte 0 in [47:40] |
| frm_len | input | 16 | Frame length in bytes excluding check sequence |
| dec_valid | output | 1 | Decision valid |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 3 | 0 OK, 1 SIZE, 2 FILTER, 3 OVERFLOW, 4 TOOLONG |
| ev_lentype | output | 1 | Length/type-received pulse |
| ev_overflow | output | 1 | Receive-size overflow pulse |
| ev_toolong | output | 1 | Too-long drop pulse |
| dec_long | output | 1 | Accepted frame is longer than standard |
| dec_len | output | 16 | Byte count to store |

## Verification
A register write and a frame evaluation can happen in the same clock. The case that matters is when the write changes the outcome for that very frame. The bench provokes this in two ways. In one, it writes the control register with complement mode on while a frame whose verdict depends on that mode is presented. In the other, it lowers the maximum size in the same cycle as a frame that fits only under the old limit. A reference model is updated after its decision is taken, and the outputs are compared to it every cycle. Both frames must therefore be judged under the old settings, and the following frame under the new ones.

// File: rtl/rx_admit_filter.sv
module rx_admit_filter #(
  parameter int LEN_W     = 16,
  parameter int HDR_MIN   = 14,
  parameter int FCS_BYTES = 4,
  parameter int STD_MAX   = 1518,
  parameter int MAXSZ_RST = 'h800
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             frm_valid,
  input  logic [47:0]      frm_dst,
  input  logic [LEN_W-1:0] frm_len,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic [2:0]       dec_reason,
  output logic             ev_lentype,
  output logic             ev_overflow,
  output logic             ev_toolong,
  output logic             dec_long,
  output logic [LEN_W-1:0] dec_len
);

  localparam logic [LEN_W:0] LEN_LIMIT = (LEN_W+1)'((1 << LEN_W) - 1 - FCS_BYTES);
  localparam logic [LEN_W:0] HDR_W     = (LEN_W+1)'(HDR_MIN);
  localparam logic [LEN_W:0] STD_W     = (LEN_W+1)'(STD_MAX);
  localparam logic [LEN_W:0] FCS_W     = (LEN_W+1)'(FCS_BYTES);
  localparam logic [2:0] RS_OK = 3'd0, RS_SIZE = 3'd1, RS_FILT = 3'd2,
                         RS_OVF = 3'd3, RS_LONG = 3'd4;

  logic [4:0]       ctl_q;
  logic             ent_en_q;
  logic [47:0]      mac_q;
  logic [LEN_W-1:0] maxsz_q;
  logic [1:0]       mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      ent_en_q <= 1'b0;
      mac_q    <= '0;
      maxsz_q  <= LEN_W'(MAXSZ_RST);
      mode_q   <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        3'd0: ctl_q         <= cfg_wdata[4:0];
        3'd1: ent_en_q      <= cfg_wdata[0];
        3'd2: mac_q[47:16]  <= cfg_wdata;
        3'd3: mac_q[15:0]   <= cfg_wdata[31:16];
        3'd4: maxsz_q       <= cfg_wdata[LEN_W-1:0];
        3'd5: mode_q        <= cfg_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_sel)
      3'd0:    cfg_rdata = {27'd0, ctl_q};
      3'd1:    cfg_rdata = {31'd0, ent_en_q};
      3'd2:    cfg_rdata = mac_q[47:16];
      3'd3:    cfg_rdata = {mac_q[15:0], 16'd0};
      3'd4:    cfg_rdata = 32'(maxsz_q);
      3'd5:    cfg_rdata = {30'd0, mode_q};
      default: cfg_rdata = '0;
    endcase
  end

  wire uc_all   = ctl_q[0];
  wire mc_ok    = ctl_q[1];
  wire bc_ok    = ctl_q[2];
  wire cplm     = ctl_q[3];
  wire cmp_en   = ctl_q[4];
  wire long_ok  = mode_q[0];
  wire strip    = mode_q[1];

  wire is_bcast = &frm_dst;
  wire is_mcast = frm_dst[40] & ~is_bcast;
  wire addr_hit = cmp_en & ent_en_q & (frm_dst == mac_q);

  logic pass_filt;
  always_comb begin
    if (is_bcast)      pass_filt = cplm | bc_ok;
    else if (is_mcast) pass_filt = cplm | mc_ok;
    else               pass_filt = uc_all | (addr_hit ^ cplm);
  end

  wire [LEN_W:0] len_x   = {1'b0, frm_len};
  wire [LEN_W:0] len_fcs = len_x + FCS_W;
  wire sane     = (len_x >= HDR_W) && (len_x <= LEN_LIMIT);
  wire over_max = len_fcs > {1'b0, maxsz_q};
  wire over_std = len_fcs > STD_W;

  logic [2:0] reason_d;
  always_comb begin
    if (!sane)                      reason_d = RS_SIZE;
    else if (!pass_filt)            reason_d = RS_FILT;
    else if (over_max)              reason_d = RS_OVF;
    else if (over_std && !long_ok)  reason_d = RS_LONG;
    else                            reason_d = RS_OK;
  end

  wire accept_d = frm_valid && (reason_d == RS_OK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid   <= 1'b0;
      dec_accept  <= 1'b0;
      dec_reason  <= RS_OK;
      ev_lentype  <= 1'b0;
      ev_overflow <= 1'b0;
      ev_toolong  <= 1'b0;
      dec_long    <= 1'b0;
      dec_len     <= '0;
    end else begin
      dec_valid   <= frm_valid;
      dec_accept  <= accept_d;
      dec_reason  <= frm_valid ? reason_d : RS_OK;
      ev_lentype  <= frm_valid && sane;
      ev_overflow <= frm_valid && (reason_d == RS_OVF);
      ev_toolong  <= frm_valid && (reason_d == RS_LONG);
      dec_long    <= accept_d && over_std;
      dec_len     <= !accept_d ? '0 : (strip ? frm_len : len_fcs[LEN_W-1:0]);
    end
  end

endmodule

// File: rtl/rx_admit_filter_chk.sv
module rx_admit_filter_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cfg_sel,
  input logic [31:0]      cfg_rdata,
  input logic             frm_valid,
  input logic [LEN_W-1:0] frm_len,
  input logic             dec_valid,
  input logic             dec_accept,
  input logic [2:0]       dec_reason,
  input logic             ev_lentype,
  input logic             ev_overflow,
  input logic             ev_toolong,
  input logic             dec_long,
  input logic [LEN_W-1:0] dec_len
);

  assert_size_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_reason == 3'd1) |-> (!ev_lentype && !ev_overflow && !ev_toolong && !dec_accept));

  assert_lentype_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_reason != 3'd1) |-> ev_lentype);

  assert_drop_events_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> (!ev_overflow && !ev_toolong && dec_reason == 3'd0));

  assert_enable_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == 3'd1) |-> (cfg_rdata[31:1] == 31'd0));

  assert_long_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_long |-> (dec_accept && !ev_toolong));

  assert_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> (dec_len == $past(frm_len) || dec_len == LEN_W'($past(frm_len) + 4)));

  assert_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (dec_valid == $past(frm_valid)));

endmodule

bind rx_admit_filter rx_admit_filter_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_rdata(cfg_rdata),
  .frm_valid(frm_valid), .frm_len(frm_len), .dec_valid(dec_valid),
  .dec_accept(dec_accept), .dec_reason(dec_reason), .ev_lentype(ev_lentype),
  .ev_overflow(ev_overflow), .ev_toolong(ev_toolong), .dec_long(dec_long),
  .dec_len(dec_len)
);

// File: tb/test_rx_admit_filter.sv
module test_rx_admit_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic frm_valid = 1'b0;
  logic [47:0] frm_dst = '0;
  logic [15:0] frm_len = '0;
  logic dec_valid, dec_accept, ev_lentype, ev_overflow, ev_toolong, dec_long;
  logic [2:0] dec_reason;
  logic [15:0] dec_len;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_admit_filter i_rx_admit_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frm_valid(frm_valid),
    .frm_dst(frm_dst), .frm_len(frm_len), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_reason(dec_reason), .ev_lentype(ev_lentype),
    .ev_overflow(ev_overflow), .ev_toolong(ev_toolong), .dec_long(dec_long),
    .dec_len(dec_len)
  );

  // reference model state
  int m_ctl, m_en, m_maxsz, m_mode;
  longint m_mac;
  int e_valid, e_acc, e_rsn, e_lt, e_ovf, e_tl, e_long, e_len;
  string e_tag;

  task automatic cmp(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic longint model_read(input int sel);
    case (sel)
      0: return m_ctl;
      1: return m_en;
      2: return (m_mac >> 16) & 64'hFFFF_FFFF;
      3: return (m_mac & 64'hFFFF) << 16;
      4: return m_maxsz;
      5: return m_mode;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 0; m_en = 0; m_mac = 0; m_maxsz = 'h800; m_mode = 0;
      e_valid = 0; e_acc = 0; e_rsn = 0; e_lt = 0; e_ovf = 0; e_tl = 0; e_long = 0; e_len = 0;
      e_tag = "R12";
    end else begin
      int l;
      bit bc, mc, hit, pass;
      l = int'(frm_len);
      bc = (frm_dst == 48'hFFFF_FFFF_FFFF);
      mc = !bc && frm_dst[40];
      e_valid = frm_valid;
      e_acc = 0; e_rsn = 0; e_lt = 0; e_ovf = 0; e_tl = 0; e_long = 0; e_len = 0;
      e_tag = "R11";
      if (frm_valid) begin
        if (bc) begin
          pass = m_ctl[3] || m_ctl[2]; e_tag = "R3";
        end else if (mc) begin
          pass = m_ctl[3] || m_ctl[1]; e_tag = "R4";
        end else begin
          hit = m_ctl[4] && m_en[0] && (longint'(frm_dst) == m_mac);
          pass = m_ctl[0] || (hit != m_ctl[3]); e_tag = "R5";
        end
        if (l < 14 || l > 65531) begin
          e_rsn = 1; e_tag = "R1";
        end else begin
          e_lt = 1;
          if (!pass) e_rsn = 2;
          else if (l + 4 > m_maxsz) begin e_rsn = 3; e_ovf = 1; e_tag = "R8"; end
          else if (l + 4 > 1518 && !m_mode[0]) begin e_rsn = 4; e_tl = 1; e_tag = "R9"; end
          else begin
            e_acc = 1;
            e_long = (l + 4 > 1518);
            e_len = m_mode[1] ? l : l + 4;
            if (e_long) e_tag = "R9";
          end
        end
      end
      if (cfg_we) begin
        case (cfg_sel)
          0: m_ctl = int'(cfg_wdata[4:0]);
          1: m_en = int'(cfg_wdata[0]);
          2: m_mac = (m_mac & 64'hFFFF) | (longint'(cfg_wdata) << 16);
          3: m_mac = (m_mac & 64'hFFFF_FFFF_0000) | longint'(cfg_wdata[31:16]);
          4: m_maxsz = int'(cfg_wdata[15:0]);
          5: m_mode = int'(cfg_wdata[1:0]);
          default: ;
        endcase
      end
    end
    #5;
    if (rst_n && !done) begin
      string rt;
      cmp("R11", "dec_valid", dec_valid, e_valid);
      cmp(e_tag, "dec_accept", dec_accept, e_acc);
      cmp(e_tag, "dec_reason", dec_reason, e_rsn);
      cmp("R2", "ev_lentype", ev_lentype, e_lt);
      cmp("R8", "ev_overflow", ev_overflow, e_ovf);
      cmp("R9", "ev_toolong", ev_toolong, e_tl);
      cmp("R9", "dec_long", dec_long, e_long);
      cmp("R10", "dec_len", dec_len, e_len);
      rt = (cfg_sel == 1) ? "R7" : (cfg_sel == 2 || cfg_sel == 3) ? "R6" : "R12";
      cmp(rt, "cfg_rdata", cfg_rdata, model_read(int'(cfg_sel)));
    end
  end

  task automatic op(input bit we, input int sel, input logic [31:0] wd,
                    input bit fv, input logic [47:0] dst, input int len);
    @(negedge clk);
    cfg_we = we; cfg_sel = 3'(sel); cfg_wdata = wd;
    frm_valid = fv; frm_dst = dst; frm_len = 16'(len);
    @(negedge clk);
    cfg_we = 0; frm_valid = 0;
  endtask

  task automatic wr(input int sel, input logic [31:0] wd);
    op(1, sel, wd, 0, '0, 0);
  endtask

  task automatic fr(input logic [47:0] dst, input int len);
    op(0, 0, '0, 1, dst, len);
  endtask

  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC  = 48'h0100_5E00_0001;
  localparam logic [47:0] ME  = 48'h0211_2233_4455;
  localparam logic [47:0] OTH = 48'h0211_2233_4456;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12: reset values at the ports
    cmp("R12", "dec_valid", dec_valid, 0);
    cmp("R12", "dec_accept", dec_accept, 0);
    cfg_sel = 3'd4; #1;
    cmp("R8", "maxsize reset", cfg_rdata, 'h800);
    cfg_sel = 3'd0; #1;
    cmp("R12", "ctrl reset", cfg_rdata, 0);

    // R6 address layout, R7 enable bits
    wr(2, 32'h0211_2233);
    wr(3, 32'h4455_ABCD);
    for (int s = 0; s < 6; s++) begin cfg_sel = 3'(s); @(negedge clk); end
    wr(1, 32'hFFFF_FFFE);
    wr(1, 32'hFFFF_FFFF);

    // R3/R4/R5 with everything off
    wr(0, 32'h0);
    fr(BC, 64); fr(MC, 64); fr(ME, 64);
    wr(0, 32'h6);            // bcast + mcast
    fr(BC, 64); fr(MC, 64); fr(ME, 64);
    wr(0, 32'h10);           // compare enable
    fr(ME, 64); fr(OTH, 64);
    wr(1, 0); fr(ME, 64); wr(1, 1);
    wr(0, 32'h18);           // compare + complement
    fr(ME, 64); fr(OTH, 64); fr(BC, 64); fr(MC, 64);
    wr(0, 32'h1);            // accept all unicast
    fr(OTH, 64); fr(BC, 64);

    // R1 size sanity
    wr(0, 32'h7);
    fr(ME, 13); fr(ME, 14); fr(BC, 0);
    wr(4, 32'hFFFF); wr(5, 1);
    fr(ME, 65531); fr(ME, 65532); fr(ME, 65535);

    // R8 programmable max
    wr(5, 0); wr(4, 100);
    fr(ME, 96); fr(ME, 97);
    wr(0, 0); fr(ME, 200);   // filter drop wins over overflow
    wr(0, 7);

    // R9 standard limit
    wr(4, 'h800);
    fr(ME, 1514); fr(ME, 1515);
    wr(5, 1); fr(ME, 1515); fr(ME, 2044); fr(ME, 2045);
    // R10 strip mode
    wr(5, 2); fr(ME, 60); fr(ME, 14); wr(5, 0); fr(ME, 60);

    // R11 write and frame in the same cycle
    wr(0, 32'h10);
    op(1, 0, 32'h18, 1, ME, 64);  // judged with old setting: accept
    fr(ME, 64);                    // now complemented: drop
    wr(0, 32'h7);
    op(1, 4, 32'd50, 1, ME, 60);   // old max 0x800: accept
    fr(ME, 60);                    // new max 50: overflow

    // back-to-back frames
    @(negedge clk);
    frm_valid = 1; frm_dst = BC; frm_len = 100; @(negedge clk);
    frm_dst = ME; frm_len = 20; @(negedge clk);
    frm_len = 5; @(negedge clk);
    frm_valid = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule